// File: doc/BRIEF.md
# Configurable Timer Counter Channel

This block is one channel of a general-purpose timer. It holds a 16-bit up-counter and an 8-bit control register that is written and read through a simple register port. The control register picks the source that advances the counter, the active edge of the external clock pin, and the event that returns the counter to zero.

The counter can advance on every system clock, on every 2nd, 4th or 8th system clock, or on edges of an external clock pin. That pin is synchronized into the system clock domain, and the counter can follow its rising edges, its falling edges, or both. Clearing can be turned off. It can follow a match/capture strobe from one of four general registers, which sit outside this block. It can also follow a clear request from a sibling channel.

When the channel clears because of its own selected general-register strobe, it drives a one-cycle pulse to the sibling. Two channels can therefore be chained so that one channel resets the other. A clear that arrives from the sibling is never sent back out.

Top module: `cnt_channel`

## Requirements
- R1: The control register resets to 0x00. A write with `ctl_we` high loads `ctl_wdata` at that clock edge. `ctl_rdata` always shows the stored value, and the stored value stays the same when no write occurs.
- R2: With source field bits [2:0] = 000, the counter increments on every system clock edge. It resets to 0x0000, and after reset it never clears on its own.
- R3: Source codes 001, 010 and 011 advance the counter once every 2, 4 and 8 clocks. The pacing comes from a free-running 3-bit divider that starts at 0 on reset and gives enable pulses when its low 1, 2 or 3 bits are all ones.
- R4: Source code 1xx counts external pin edges. The pin goes through two synchronizer flops and an edge detector, so a new level first sampled at clock edge n changes the count at edge n+2. Edge field bits [4:3] = 00 counts rising edges and 01 counts falling edges.
- R5: Edge field values 10 and 11 count both rising and falling pin edges, with at most one increment per system clock.
- R6: Clear field bits [7:5] = 000 or 100 disables clearing, whatever the strobes and the sibling input do.
- R7: Clear codes 001, 010, 101 and 110 clear the counter at a clock edge where `gr_evt[0]`, `gr_evt[1]`, `gr_evt[2]` or `gr_evt[3]` is high, in that order.
- R8: Clear codes 011 and 111 clear the counter when `sib_clr_in` is high. In these modes `clr_evt_out` stays low.
- R9: A clear and an increment in the same cycle leave the counter at 0x0000.
- R10: `clr_evt_out` is high, in the same cycle, exactly when the strobe selected by clear codes 001/010/101/110 is high. Otherwise it is low.
- R11: An increment from 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| ext_pin | input | 1 | External count clock pin (asynchronous) |
| gr_evt | input | 4 | Match/capture strobes from general registers A..D (bit 0 = A) |
| sib_clr_in | input | 1 | Clear request from the sibling channel |
| count | output | 16 | Counter value |
| clr_evt_out | output | 1 | One-cycle pulse on this channel's own selected clear |

## Verification
Most internal state shows up on `count` within one cycle. A divider phase that is off by one moves every prescaled increment to the wrong edge, and this shows as a wrong count on the first enable pulse. A synchronizer stage too many or too few shifts each external-pin increment by one clock, so the per-cycle comparison against the reference model catches it at the first pin edge. A decoding error in the clear field shows as a counter that keeps running, or that drops to zero, on the first strobe. It also shows as a `clr_evt_out` pulse that appears or goes missing in that same cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  localparam int CTL_W = 8;
  localparam int GR_N  = 4;

  // control register layout
  typedef struct packed {
    logic [2:0] clr;       // clear source
    logic [1:0] edge_sel;  // external edge choice
    logic [2:0] src;       // count source
  } ctl_t;

  // own (general register) clear hit for a clear code
  function automatic logic own_clear(input logic [2:0] code,
                                     input logic [GR_N-1:0] evt);
    logic hit;
    case (code)
      3'b001:  hit = evt[0];
      3'b010:  hit = evt[1];
      3'b101:  hit = evt[2];
      3'b110:  hit = evt[3];
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

  // sibling-driven clear mode
  function automatic logic sync_mode(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

  // external pin count decision from edge choice
  function automatic logic ext_count(input logic [1:0] edge_sel,
                                     input logic rise, input logic fall);
    logic hit;
    if (edge_sel[1])      hit = rise | fall;
    else if (edge_sel[0]) hit = fall;
    else                  hit = rise;
    return hit;
  endfunction

endpackage

// File: rtl/cnt_prescale.sv
module cnt_prescale #(
  parameter int DIV_W = 3,
  localparam int SEL_W = $clog2(DIV_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   tick_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // tick_vec[k]: pulse once every 2**k clocks
  for (genvar k = 0; k <= DIV_W; k++) begin : g_tap
    if (k == 0) begin : g_full
      assign tick_vec[k] = 1'b1;
    end else begin : g_div
      assign tick_vec[k] = &div_q[k-1:0];
    end
  end

  assign tick = (int'(sel) <= DIV_W) ? tick_vec[sel] : 1'b0;

  // R3
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '1) |=> (div_q == '0));

endmodule

// File: rtl/cnt_edge_det.sv
module cnt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R5
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));

endmodule

// File: rtl/cnt_clr_sel.sv
module cnt_clr_sel
  import cnt_pkg::*;
(
  input  logic [2:0]      code,
  input  logic [GR_N-1:0] evt,
  input  logic            sib,
  output logic            own_hit,
  output logic            sync_hit
);

  assign own_hit  = own_clear(code, evt);
  assign sync_hit = sync_mode(code) & sib;

endmodule

// File: rtl/cnt_channel.sv
module cnt_channel
  import cnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic [CTL_W-1:0]       ctl_wdata,
  output logic [CTL_W-1:0]       ctl_rdata,
  input  logic                   ext_pin,
  input  logic [GR_N-1:0]        gr_evt,
  input  logic                   sib_clr_in,
  output logic [CNT_W-1:0]       count,
  output logic                   clr_evt_out
);

  localparam int DIV_W = 3;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] count_q;
  logic             div_tick, ext_rise, ext_fall, ext_tick, tick;
  logic             own_hit, sync_hit, clr_any;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic inc,
                                                  input logic clr);
    logic [CNT_W-1:0] nxt;
    if (clr)      nxt = '0;
    else if (inc) nxt = cur + 1'b1;
    else          nxt = cur;
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  cnt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctl_q.src[1:0]),
    .tick (div_tick)
  );

  cnt_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  cnt_clr_sel u_clr (
    .code    (ctl_q.clr),
    .evt     (gr_evt),
    .sib     (sib_clr_in),
    .own_hit (own_hit),
    .sync_hit(sync_hit)
  );

  assign ext_tick = ext_count(ctl_q.edge_sel, ext_rise, ext_fall);
  assign tick     = ctl_q.src[2] ? ext_tick : div_tick;
  assign clr_any  = own_hit | sync_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count(count_q, tick, clr_any);
  end

  assign count       = count_q;
  assign ctl_rdata   = ctl_q;
  assign clr_evt_out = own_hit;

  // R1
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_any) |=> $stable(count_q));

  // R6
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.clr[1:0] == 2'b00) |-> !clr_any);

  // R8
  no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.clr[1:0] == 2'b11) |-> !clr_evt_out);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && tick) |=> (count_q == '0));

  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_any && count_q == '1) |=> (count_q == '0));

endmodule

// File: tb/cnt_channel_bench.sv
module cnt_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        ext_pin = 1'b0;
  logic [3:0]  gr_evt = '0;
  logic        sib_clr_in = 1'b0;
  logic [15:0] count;
  logic        clr_evt_out;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_ctl, m_cnt, cyc;
  bit pq[$];

  always #2 clk = ~clk;  // 250 MHz

  cnt_channel u_cnt_channel (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ext_pin(ext_pin), .gr_evt(gr_evt),
    .sib_clr_in(sib_clr_in), .count(count), .clr_evt_out(clr_evt_out)
  );

  function automatic bit exp_own(int ctl, logic [3:0] ev);
    int code = (ctl >> 5) & 7;
    return (code == 1 && ev[0]) || (code == 2 && ev[1]) ||
           (code == 5 && ev[2]) || (code == 6 && ev[3]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_cnt = 0; cyc = 0;
      pq = '{1'b0, 1'b0, 1'b0};
    end else begin
      int s, e, code;
      bit r, f, inc, clr;
      s = m_ctl & 7; e = (m_ctl >> 3) & 3; code = (m_ctl >> 5) & 7;
      r = pq[1] && !pq[2];
      f = !pq[1] && pq[2];
      if (s >= 4) inc = (e >= 2) ? (r || f) : ((e == 1) ? f : r);
      else        inc = ((cyc + 1) % (1 << s)) == 0;
      clr = exp_own(m_ctl, gr_evt) || ((code == 3 || code == 7) && sib_clr_in);
      if (clr)      m_cnt = 0;
      else if (inc) m_cnt = (m_cnt + 1) % 65536;
      cyc = (cyc + 1) % 8;
      pq.push_front(ext_pin);
      void'(pq.pop_back());
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(count == m_cnt[15:0], tag, count, m_cnt);
    chk(ctl_rdata == m_ctl[7:0], "R1 readback", ctl_rdata, m_ctl);
    chk(clr_evt_out == exp_own(m_ctl, gr_evt), "R10 clear event", clr_evt_out,
        exp_own(m_ctl, gr_evt));
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step("R1 write");
    ctl_we = 1'b0;
  endtask

  task automatic run_mixed(input string tag, input int n, input int pin_per);
    for (int i = 0; i < n; i++) begin
      gr_evt = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      sib_clr_in = ($urandom_range(0, 6) == 0);
      if (pin_per > 0 && (i % pin_per) == 0) ext_pin = ~ext_pin;
      step(tag);
    end
    gr_evt = '0; sib_clr_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R2 reset state
    chk(ctl_rdata == 8'h00, "R1 reset ctl", ctl_rdata, 0);
    chk(count == 16'h0, "R2 reset count", count, 0);
    chk(clr_evt_out == 1'b0, "R10 reset event", clr_evt_out, 0);
    rst_n = 1'b1;
    step("R2 first count");
    chk(count == 16'd1, "R2 counts every clock", count, 1);
    run_mixed("R2 no clear after reset", 30, 0);

    // R3 prescaler
    wr(8'b000_00_001); run_mixed("R3 div2", 40, 0);
    wr(8'b000_00_010); run_mixed("R3 div4", 40, 0);
    wr(8'b000_00_011); run_mixed("R3 div8", 48, 0);

    // R4 / R5 external pin
    wr(8'b000_00_100); run_mixed("R4 rising", 60, 3);
    wr(8'b000_01_101); run_mixed("R4 falling", 60, 4);
    wr(8'b000_10_110); run_mixed("R5 both edges", 60, 3);
    wr(8'b000_11_111); run_mixed("R5 both fast", 40, 1);

    // R6 disabled clear codes
    wr(8'b100_00_000); run_mixed("R6 code 100", 40, 0);
    wr(8'b000_00_000); run_mixed("R6 code 000", 20, 0);

    // R7 general register clear selection
    wr(8'b001_00_000); run_mixed("R7 reg A", 40, 0);
    wr(8'b010_00_001); run_mixed("R7 reg B", 40, 0);
    wr(8'b101_00_000); run_mixed("R7 reg C", 40, 0);
    wr(8'b110_00_100); run_mixed("R7 reg D", 40, 2);

    // R8 synchronous clear, no echo
    wr(8'b011_00_000); run_mixed("R8 sync 011", 40, 0);
    wr(8'b111_00_010); run_mixed("R8 sync 111", 40, 0);
    gr_evt = 4'hF; sib_clr_in = 1'b0; step("R8 strobes ignored");
    chk(clr_evt_out == 1'b0, "R8 no echo", clr_evt_out, 0);
    gr_evt = '0;

    // R9 clear beats increment
    wr(8'b001_00_000);
    repeat (5) step("R9 run");
    gr_evt = 4'b0001; step("R9 clear");
    chk(count == 16'h0, "R9 clear over increment", count, 0);
    chk(clr_evt_out == 1'b1, "R10 pulse with A", clr_evt_out, 1);
    gr_evt = '0; step("R10 pulse drops");
    chk(clr_evt_out == 1'b0, "R10 one cycle", clr_evt_out, 0);

    // R11 wrap: count is 1 here
    for (int i = 0; i < 65534; i++) step("R11 climb");
    chk(count == 16'hFFFF, "R11 at max", count, 16'hFFFF);
    step("R11 wrap");
    chk(count == 16'h0000, "R11 wrapped", count, 0);
    step("R11 after wrap");
    chk(count == 16'h0001, "R11 resumes", count, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule